// File: doc/BRIEF.md
# CRC7 Command Frame Encoder

This block assembles the command header that a host controller sends to a wireless-module slave over a byte-wide serial link. A single-cycle start pulse captures an opcode, a 24-bit address, a 32-bit data word, a 24-bit transfer size, a clockless flag and a CRC-enable flag. The block then presents the header one byte at a time on a valid/ready stream. When CRC is enabled, the last byte is a CRC7 trailer.

The layout and the length of the header depend on the opcode. The CRC7 is accumulated bit-serially while the bytes are handed over, so no lookup table is needed. The total frame length is reported from the cycle after the start pulse. An opcode that the block does not recognise raises an error flag, and no byte is sent. The serial shifter, the response handling and the data phase belong to neighbouring blocks.

Top module: `cmd_frame_enc`

## Requirements
- R1: After reset, busy, out_valid, out_last and bad_op are low and frame_len is 0.
- R2: A byte is taken only in a cycle where out_valid and out_ready are both high. While out_ready is low, out_valid and out_byte hold their values.
- R3: The first byte is the opcode. The total length including the trailer is 5 for 0xCA, 0xC4, 0xC5, 0xC6 and 0xCF. It is 7 for 0xC1 and 0xC2, 8 for 0xC3, 0xC7 and 0xC8, and 9 for 0xC9.
- R4: Opcodes 0xC1, 0xC2, 0xC7, 0xC8, 0xC9 and 0xCA send the address as 3 bytes, most significant byte first, in bytes 1 to 3. Opcodes 0xC3 and 0xC4 send only address bits 15:0, high byte first, in bytes 1 and 2. Byte 3 of 0xC4 is 0x00.
- R5: With the clockless flag set, bit 7 of byte 1 is forced to 1 for 0xC3 and 0xC4. For every other opcode the flag has no effect.
- R6: Opcodes 0xC5 and 0xC6 send three 0x00 bytes after the opcode. Opcode 0xCF sends three 0xFF bytes after the opcode.
- R7: Opcodes 0xC1 and 0xC2 send size bits 15:0 in bytes 4 and 5. Opcodes 0xC7 and 0xC8 send size bits 23:0 in bytes 4 to 6. The data word goes out most significant byte first, in bytes 3 to 6 for 0xC3 and in bytes 4 to 7 for 0xC9.
- R8: With CRC enabled, the trailer is the CRC7 of all preceding bytes, shifted left by one, so bit 0 is 0. The CRC uses polynomial x^7+x^3+1, a register seeded to 0x7F, and takes each byte MSB first.
- R9: With CRC disabled, the trailer is left out and the frame is one byte shorter.
- R10: An unknown opcode sets bad_op from the cycle after start until the next accepted start. In that case out_valid stays low and frame_len is 0.
- R11: A start while busy is ignored. out_last is high exactly on the final byte. busy falls in the cycle after that byte is taken.
- R12: frame_len shows the total length from the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture inputs and begin a frame (only when not busy) |
| opcode | input | 8 | Command code |
| addr | input | 24 | Target address |
| wdata | input | 32 | Data word for write commands |
| xfer_size | input | 24 | Transfer size for DMA commands |
| clockless | input | 1 | Mark an internal access as clockless |
| crc_en | input | 1 | Append the CRC7 trailer |
| out_ready | input | 1 | Downstream accepts the current byte |
| out_valid | output | 1 | out_byte holds a frame byte |
| out_byte | output | 8 | Current frame byte |
| out_last | output | 1 | Current byte is the final one |
| busy | output | 1 | Frame in progress |
| frame_len | output | 4 | Total frame length in bytes |
| bad_op | output | 1 | Last start carried an unknown opcode |

## Verification
frame_len, bad_op and the opcode byte are all due one cycle after the clock edge that samples start. Each following byte is due one cycle after the edge on which the previous byte was taken, and busy falls one cycle after the final byte is taken. The bench drives its inputs on falling edges and samples on the next falling edge. It compares a byte only where the handshake decides which byte must be showing. Ready is withheld in some vectors, so a stalled byte must still show the same expected value one or more cycles later.

// File: rtl/cmdf_pkg.sv
package cmdf_pkg;
   localparam int HDR_MAX = 8;
   localparam int LEN_W   = 4;

   typedef enum logic [7:0] {
      OP_DMA_WR   = 8'hC1,
      OP_DMA_RD   = 8'hC2,
      OP_INT_WR   = 8'hC3,
      OP_INT_RD   = 8'hC4,
      OP_STOP     = 8'hC5,
      OP_AGAIN    = 8'hC6,
      OP_XDMA_WR  = 8'hC7,
      OP_XDMA_RD  = 8'hC8,
      OP_WORD_WR  = 8'hC9,
      OP_WORD_RD  = 8'hCA,
      OP_SOFT_RST = 8'hCF
   } cmd_op_e;

   typedef logic [HDR_MAX-1:0][7:0] hdr_t;
endpackage

// File: rtl/cmdf_layout.sv
module cmdf_layout
   import cmdf_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   parameter int SIZE_W = 24
) (
   input  logic [7:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SIZE_W-1:0] xsize,
   input  logic              clockless,
   output hdr_t              hdr,
   output logic [LEN_W-1:0]  hdr_len,
   output logic              known
);
   logic [7:0] int_hi;

   // internal accesses carry only the low 16 address bits; clockless sets bit 7
   assign int_hi = {addr[15] | clockless, addr[14:8]};

   always_comb begin
      hdr     = '0;
      hdr[0]  = op;
      known   = 1'b1;
      hdr_len = LEN_W'(4);
      case (op)
         OP_DMA_WR, OP_DMA_RD: begin
            hdr[1]  = addr[23:16];
            hdr[2]  = addr[15:8];
            hdr[3]  = addr[7:0];
            hdr[4]  = xsize[15:8];
            hdr[5]  = xsize[7:0];
            hdr_len = LEN_W'(6);
         end
         OP_XDMA_WR, OP_XDMA_RD: begin
            hdr[1]  = addr[23:16];
            hdr[2]  = addr[15:8];
            hdr[3]  = addr[7:0];
            hdr[4]  = xsize[23:16];
            hdr[5]  = xsize[15:8];
            hdr[6]  = xsize[7:0];
            hdr_len = LEN_W'(7);
         end
         OP_INT_WR: begin
            hdr[1]  = int_hi;
            hdr[2]  = addr[7:0];
            hdr[3]  = wdata[31:24];
            hdr[4]  = wdata[23:16];
            hdr[5]  = wdata[15:8];
            hdr[6]  = wdata[7:0];
            hdr_len = LEN_W'(7);
         end
         OP_INT_RD: begin
            hdr[1]  = int_hi;
            hdr[2]  = addr[7:0];
            hdr[3]  = 8'h00;
         end
         OP_WORD_WR: begin
            hdr[1]  = addr[23:16];
            hdr[2]  = addr[15:8];
            hdr[3]  = addr[7:0];
            hdr[4]  = wdata[31:24];
            hdr[5]  = wdata[23:16];
            hdr[6]  = wdata[15:8];
            hdr[7]  = wdata[7:0];
            hdr_len = LEN_W'(8);
         end
         OP_WORD_RD: begin
            hdr[1]  = addr[23:16];
            hdr[2]  = addr[15:8];
            hdr[3]  = addr[7:0];
         end
         OP_STOP, OP_AGAIN: begin
            hdr[1]  = 8'h00;
            hdr[2]  = 8'h00;
            hdr[3]  = 8'h00;
         end
         OP_SOFT_RST: begin
            hdr[1]  = 8'hFF;
            hdr[2]  = 8'hFF;
            hdr[3]  = 8'hFF;
         end
         default: begin
            known   = 1'b0;
            hdr_len = '0;
         end
      endcase
   end

   // R3: every known opcode has a header of 4 to 8 bytes before the trailer
   always_comb begin
      if (known) begin
         hdr_len_range_chk: assert (hdr_len >= LEN_W'(4) && hdr_len <= LEN_W'(HDR_MAX));
      end
   end
endmodule

// File: rtl/cmdf_crc7.sv
module cmdf_crc7 #(
   parameter int               CRC_W = 7,
   parameter logic [CRC_W-1:0] POLY  = 7'h09
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [7:0]       din,
   output logic [CRC_W-1:0] crc_out
);
   // one byte folded into the remainder, MSB first
   always_comb begin
      logic [CRC_W-1:0] r;
      logic             fb;
      r = crc_in;
      for (int b = 7; b >= 0; b--) begin
         fb = r[CRC_W-1] ^ din[b];
         r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      crc_out = r;
   end
endmodule

// File: rtl/cmd_frame_enc.sv
module cmd_frame_enc
   import cmdf_pkg::*;
#(
   parameter int         ADDR_W   = 24,
   parameter int         DATA_W   = 32,
   parameter int         SIZE_W   = 24,
   parameter int         CRC_W    = 7,
   parameter logic [6:0] CRC_POLY = 7'h09,
   parameter logic [6:0] CRC_SEED = 7'h7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SIZE_W-1:0] xfer_size,
   input  logic              clockless,
   input  logic              crc_en,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   output logic              out_last,
   output logic              busy,
   output logic [LEN_W-1:0]  frame_len,
   output logic              bad_op
);
   localparam int IDX_W = $clog2(HDR_MAX + 1);

   if (ADDR_W != 24 || SIZE_W != 24 || DATA_W != 32) begin : g_bad_width
      $error("cmd_frame_enc: field widths are fixed by the frame layout");
   end
   if (CRC_W != 7) begin : g_bad_crc
      $error("cmd_frame_enc: trailer holds a 7-bit CRC");
   end
   if (LEN_W < $clog2(HDR_MAX + 2)) begin : g_bad_len
      $error("cmd_frame_enc: length field too narrow");
   end

   hdr_t             hdr_new, hdr_q;
   logic [LEN_W-1:0] hlen_new, hlen_q, flen_q, last_idx;
   logic             op_known;
   logic [IDX_W-1:0] idx_q;
   logic [CRC_W-1:0] crc_q, crc_nxt;
   logic             busy_q, bad_q;
   logic [7:0]       hdr_byte;
   logic             take, at_trailer, accept;

   cmdf_layout #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
   ) u_layout (
      .op(opcode), .addr(addr), .wdata(wdata), .xsize(xfer_size),
      .clockless(clockless), .hdr(hdr_new), .hdr_len(hlen_new), .known(op_known)
   );

   assign hdr_byte = hdr_q[idx_q[$clog2(HDR_MAX)-1:0]];

   cmdf_crc7 #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .crc_in(crc_q), .din(hdr_byte), .crc_out(crc_nxt)
   );

   assign accept     = start && !busy_q;
   assign take       = busy_q && out_ready;
   assign at_trailer = (LEN_W'(idx_q) == hlen_q);
   assign last_idx   = flen_q - LEN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         bad_q  <= 1'b0;
         idx_q  <= '0;
         hdr_q  <= '0;
         hlen_q <= '0;
         flen_q <= '0;
         crc_q  <= CRC_SEED;
      end else if (accept) begin
         idx_q <= '0;
         crc_q <= CRC_SEED;
         hdr_q <= hdr_new;
         if (op_known) begin
            busy_q <= 1'b1;
            bad_q  <= 1'b0;
            hlen_q <= hlen_new;
            flen_q <= hlen_new + LEN_W'(crc_en);
         end else begin
            bad_q  <= 1'b1;
            hlen_q <= '0;
            flen_q <= '0;
         end
      end else if (take) begin
         if (!at_trailer) crc_q <= crc_nxt;
         if (LEN_W'(idx_q) == last_idx) busy_q <= 1'b0;
         else                           idx_q  <= idx_q + IDX_W'(1);
      end
   end

   assign busy      = busy_q;
   assign out_valid = busy_q;
   assign out_byte  = at_trailer ? {crc_q, 1'b0} : hdr_byte;
   assign out_last  = busy_q && (LEN_W'(idx_q) == last_idx);
   assign frame_len = flen_q;
   assign bad_op    = bad_q;

   // R2
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_byte));
   // R3
   opcode_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && op_known |=> out_valid && out_byte == $past(opcode));
   // R8
   trailer_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && at_trailer |-> out_last && out_byte[0] == 1'b0);
   // R10
   bad_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op |-> !out_valid && frame_len == '0);
   // R11
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(frame_len));
   // R11
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last && out_ready |=> !busy);
   // R12
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> frame_len >= LEN_W'(4) && frame_len <= LEN_W'(9));
endmodule

// File: tb/tb_cmd_frame_enc.sv
module tb_cmd_frame_enc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = '0;
   logic [23:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [23:0] xfer_size = '0;
   logic        clockless = 1'b0;
   logic        crc_en = 1'b0;
   logic        out_ready = 1'b0;
   logic        out_valid, out_last, busy, bad_op;
   logic [7:0]  out_byte;
   logic [3:0]  frame_len;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   cmd_frame_enc dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
      .wdata(wdata), .xfer_size(xfer_size), .clockless(clockless), .crc_en(crc_en),
      .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte),
      .out_last(out_last), .busy(busy), .frame_len(frame_len), .bad_op(bad_op)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // {op, addr, data, size, clockless, crc_en, stall}
   localparam int NV = 14;
   localparam logic [90:0] VEC [NV] = '{
      {8'hCA, 24'h123456, 32'h0,        24'h0,      1'b0, 1'b1, 1'b0},
      {8'hC9, 24'hABCDEF, 32'hDEADBEEF, 24'h0,      1'b0, 1'b1, 1'b1},
      {8'hC1, 24'h010203, 32'h0,        24'h00A5C3, 1'b0, 1'b1, 1'b0},
      {8'hC2, 24'hFF0080, 32'h0,        24'h7F0102, 1'b1, 1'b1, 1'b1},
      {8'hC7, 24'h400000, 32'h0,        24'h123456, 1'b0, 1'b1, 1'b0},
      {8'hC8, 24'h00FFFF, 32'h0,        24'hFEDCBA, 1'b0, 1'b0, 1'b1},
      {8'hC3, 24'hEE1234, 32'h01234567, 24'h0,      1'b1, 1'b1, 1'b0},
      {8'hC3, 24'h001234, 32'h89ABCDEF, 24'h0,      1'b0, 1'b0, 1'b0},
      {8'hC4, 24'h000030, 32'h0,        24'h0,      1'b1, 1'b1, 1'b1},
      {8'hC4, 24'h00E824, 32'h0,        24'h0,      1'b0, 1'b1, 1'b0},
      {8'hC5, 24'h777777, 32'h0,        24'h0,      1'b1, 1'b1, 1'b0},
      {8'hC6, 24'h0,      32'h0,        24'h0,      1'b0, 1'b0, 1'b0},
      {8'hCF, 24'h0,      32'h0,        24'h0,      1'b0, 1'b1, 1'b1},
      {8'hCA, 24'h001000, 32'h0,        24'h0,      1'b1, 1'b0, 1'b0}
   };

   // expected frame from the requirements; trailer with an 8-bit aligned register
   task automatic build(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                        input logic [23:0] s, input logic cl, input logic ce,
                        output logic [7:0] eb [9], output int n);
      logic [7:0] r;
      logic [7:0] hi;
      for (int i = 0; i < 9; i++) eb[i] = 8'h00;
      eb[0] = op;
      hi = {a[15] | cl, a[14:8]};
      case (op)
         8'hC1, 8'hC2: begin eb[1]=a[23:16]; eb[2]=a[15:8]; eb[3]=a[7:0]; eb[4]=s[15:8]; eb[5]=s[7:0]; n=6; end
         8'hC7, 8'hC8: begin eb[1]=a[23:16]; eb[2]=a[15:8]; eb[3]=a[7:0]; eb[4]=s[23:16]; eb[5]=s[15:8]; eb[6]=s[7:0]; n=7; end
         8'hC3: begin eb[1]=hi; eb[2]=a[7:0]; eb[3]=d[31:24]; eb[4]=d[23:16]; eb[5]=d[15:8]; eb[6]=d[7:0]; n=7; end
         8'hC4: begin eb[1]=hi; eb[2]=a[7:0]; n=4; end
         8'hC9: begin eb[1]=a[23:16]; eb[2]=a[15:8]; eb[3]=a[7:0]; eb[4]=d[31:24]; eb[5]=d[23:16]; eb[6]=d[15:8]; eb[7]=d[7:0]; n=8; end
         8'hCA: begin eb[1]=a[23:16]; eb[2]=a[15:8]; eb[3]=a[7:0]; n=4; end
         8'hCF: begin eb[1]=8'hFF; eb[2]=8'hFF; eb[3]=8'hFF; n=4; end
         default: n=4;
      endcase
      if (ce) begin
         r = 8'hFE;
         for (int i = 0; i < n; i++) begin
            r = r ^ eb[i];
            for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'h12) : (r << 1);
         end
         eb[n] = r & 8'hFE;
         n = n + 1;
      end
   endtask

   function automatic string tag_for(input logic [7:0] op, input int k, input int n, input logic ce);
      if (k == 0) return "R3";
      if (ce && k == n - 1) return "R8";
      if (op == 8'hC5 || op == 8'hC6 || op == 8'hCF) return "R6";
      if ((op == 8'hC3 || op == 8'hC4) && k == 1) return "R5";
      if (k <= 3) return "R4";
      return "R7";
   endfunction

   task automatic drain(input logic [7:0] op, input logic ce, input logic stall,
                        input logic [7:0] eb [9], input int n);
      int k = 0;
      int g = 0;
      logic rdy;
      while (k < n && g < 64) begin
         rdy = stall ? (g % 3 != 1) : 1'b1;
         out_ready = rdy;
         chk(out_valid == 1'b1, "R2", 32'(out_valid), 32'd1);
         chk(out_byte == eb[k], tag_for(op, k, n, ce), 32'(out_byte), 32'(eb[k]));
         chk(out_last == (k == n - 1), "R11", 32'(out_last), 32'(k == n - 1));
         if (rdy) k++;
         g++;
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(busy == 1'b0 && out_valid == 1'b0, "R11", 32'(busy), 32'd0);
   endtask

   task automatic launch(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                         input logic [23:0] s, input logic cl, input logic ce);
      opcode = op; addr = a; wdata = d; xfer_size = s; clockless = cl; crc_en = ce;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      logic [7:0] eb [9];
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 0 && out_valid == 0 && out_last == 0, "R1", {busy, out_valid, out_last}, 0);
      chk(bad_op == 0 && frame_len == 0, "R1", {bad_op, frame_len}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic [90:0] e;
         e = VEC[v];
         build(e[90:83], e[82:59], e[58:27], e[26:3], e[2], e[1], eb, n);
         launch(e[90:83], e[82:59], e[58:27], e[26:3], e[2], e[1]);
         // R12, R9 (crc off shortens by one)
         chk(frame_len == 4'(n), e[1] ? "R12" : "R9", 32'(frame_len), 32'(n));
         drain(e[90:83], e[1], e[0], eb, n);
      end

      // R10: unknown opcodes
      launch(8'hC0, 24'h1, 32'h2, 24'h3, 1'b0, 1'b1);
      chk(bad_op == 1'b1, "R10", 32'(bad_op), 32'd1);
      chk(frame_len == 0 && out_valid == 0, "R10", {frame_len, out_valid}, 0);
      out_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk(out_valid == 0 && busy == 0 && bad_op == 1, "R10", {out_valid, busy, bad_op}, 1);
      out_ready = 1'b0;
      launch(8'hCB, 24'h0, 32'h0, 24'h0, 1'b1, 1'b0);
      chk(bad_op == 1'b1 && out_valid == 0, "R10", {bad_op, out_valid}, 32'h2);
      build(8'hC5, 24'h0, 32'h0, 24'h0, 1'b0, 1'b1, eb, n);
      launch(8'hC5, 24'h0, 32'h0, 24'h0, 1'b0, 1'b1);
      chk(bad_op == 1'b0, "R10", 32'(bad_op), 32'd0);

      // R11: start while busy is ignored, frame continues unchanged
      start = 1'b1; opcode = 8'hC9; crc_en = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(frame_len == 4'd5 && out_byte == 8'hC5, "R11", {frame_len, out_byte}, {4'd5, 8'hC5});
      drain(8'hC5, 1'b1, 1'b1, eb, n);

      // R5: clockless has no effect on a non-internal opcode
      build(8'hC1, 24'h112233, 32'h0, 24'h4455, 1'b0, 1'b1, eb, n);
      launch(8'hC1, 24'h112233, 32'h0, 24'h4455, 1'b1, 1'b1);
      chk(out_byte == 8'hC1, "R5", 32'(out_byte), 32'hC1);
      drain(8'hC1, 1'b1, 1'b0, eb, n);

      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule